// File: doc/BRIEF.md
# Serial Control Register Slave

This block lets a host microcontroller reach a bank of fifteen 16-bit control and status registers over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output. Every transaction is 32 bits long, sent most significant bit first. The host sends a command byte, then an address byte, then a 16-bit data word. During a read, the block drives the data word back on the output line.

The select, clock and data pins come from outside the chip. They pass through two-flop synchronisers into the system clock, and serial clock edges are detected in that domain. The block then decodes the command and checks the address against a fixed access map. Each register is read-write, read-only, write-only or reserved. Read-only values are inputs supplied by the surrounding decoder logic.

The block drives these outputs toward the rest of the chip:
- every read-write register;
- the volume register, split into its two channel bytes;
- a program-memory write port whose base address steps by itself after each data write;
- one write strobe per address.

Top module: `ctlRegSlave`

## Requirements
- R1: A frame whose command byte is 0x02 writes its 16-bit word into the addressed read-write register (0x00, 0x01, 0x03, 0x0A, 0x0B, 0x0D, 0x0E). Bits are taken on rising serial clock edges, MSB first, in the order command byte, address byte, data word.
- R2: A frame whose command byte is 0x03 returns the addressed register on `sdo`, MSB first. Each bit changes after a falling serial clock edge, so the host samples it on the next rising edge. The first data bit is valid before the 17th rising edge. `sdo` is 0 outside a read data phase.
- R3: A command byte other than 0x02 or 0x03 changes no register, raises no strobe and leaves `sdo` at 0.
- R4: Addresses 0x04, 0x05, 0x08 and 0x09 read `decodeTime`, `sampleData`, `header0` and `header1`. Writes to these addresses are ignored.
- R5: Addresses 0x06 and 0x07 are write-only and read as zero. Addresses 0x02 and 0x0C, and every address above 0x0E, ignore writes and read as zero.
- R6: The volume register at 0x0B carries the left channel in bits 15:8 and the right channel in bits 7:0. These bytes drive `volLeft` and `volRight`. 0x00 is the loudest level and 0xFF the quietest.
- R7: A write to 0x06 raises `progWrStb` for one system cycle. During that cycle, `progDataOut` holds the word and `progAddrOut` holds the current base address. The base address then increases by one. A write to 0x07 sets the base address.
- R8: If select rises before the 32nd rising serial clock edge, the frame is dropped and no register or strobe changes. The next frame starts cleanly from bit 0.
- R9: Mode bit 2 (soft reset) clears itself, so `modeOut[2]` is high for exactly one system cycle after it is written as 1. Mode bit 4 drives `powerDown`.
- R10: After reset, all registers, the program base address, `sdo` and all strobes are 0.
- R11: Each accepted write to address a (a writable address 0x00–0x0E) pulses `wrStb[a]` for exactly one cycle. No other strobe bit rises for that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| decodeTime | input | 16 | Read-only value at 0x04 |
| sampleData | input | 16 | Read-only value at 0x05 |
| header0 | input | 16 | Read-only value at 0x08 |
| header1 | input | 16 | Read-only value at 0x09 |
| modeOut | output | 16 | Mode register (0x00) |
| powerDown | output | 1 | Mode bit 4 |
| statusOut | output | 16 | Status register (0x01) |
| clockOut | output | 16 | Clock configuration register (0x03) |
| appAddrOut | output | 16 | Application start register (0x0A) |
| volLeft | output | 8 | Left volume, 0x00 loudest |
| volRight | output | 8 | Right volume, 0x00 loudest |
| appCtrl0Out | output | 16 | Application control register (0x0D) |
| appCtrl1Out | output | 16 | Application control register (0x0E) |
| progDataOut | output | 16 | Last program data word written (0x06) |
| progAddrOut | output | 16 | Program base address (0x07) |
| progWrStb | output | 1 | One-cycle program write pulse |
| wrStb | output | 15 | One-cycle write strobe per address |

## Verification
The assertions check these properties on every cycle:
- The frame bit count never passes 32.
- A register write is issued only once a full 32-bit frame has arrived.
- `sdo` moves only after a detected falling clock edge.
- At most one write strobe is high.
- The soft-reset bit never stays high for two cycles.
- The program base address steps by one after every program write.

Some behaviours depend on the access map and on the host's view of a whole frame, and only the bench scenarios can show them:
- read-back values, MSB-first order and the number of sampling edges;
- ignored writes to read-only, reserved and out-of-range addresses;
- a rejected command byte;
- a frame cut short by select rising early;
- the split of the volume bytes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int DW    = 16;
  localparam int AW    = 8;
  localparam int NREG  = 15;
  localparam int IDXW  = $clog2(NREG);
  localparam int NSLOT = 1 << IDXW;
  localparam int FRAME = 2 * AW + DW;

  localparam logic [AW-1:0] CMD_RD = 8'h03;
  localparam logic [AW-1:0] CMD_WR = 8'h02;

  localparam int A_MODE = 0;
  localparam int A_STAT = 1;
  localparam int A_CLK  = 3;
  localparam int A_TIME = 4;
  localparam int A_SMP  = 5;
  localparam int A_PDAT = 6;
  localparam int A_PADR = 7;
  localparam int A_HDR0 = 8;
  localparam int A_HDR1 = 9;
  localparam int A_APPA = 10;
  localparam int A_VOL  = 11;
  localparam int A_APC0 = 13;
  localparam int A_APC1 = 14;

  localparam int MODE_SRST = 2;
  localparam int MODE_PDN  = 4;

  // access map, one bit per address slot
  localparam logic [NSLOT-1:0] RW_MASK = 16'b0110_1100_0000_1011;
  localparam logic [NSLOT-1:0] WO_MASK = 16'b0000_0000_1100_0000;

  typedef struct packed {
    logic          wrEn;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } ctlStrobe_t;
endpackage

// File: rtl/ctlSerialCtrl.sv
module ctlSerialCtrl
  import ctl_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selN,
  input  logic          sclk,
  input  logic          sdi,
  input  logic [DW-1:0] rdData,
  output ctlStrobe_t    strobe,
  output logic          sdo
);
  localparam int CW = $clog2(FRAME + 1);

  logic [SYNC-1:0] selSy, clkSy, dinSy;
  logic selS, clkS, dinS, clkPrev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSy   <= '1;
      clkSy   <= '0;
      dinSy   <= '0;
      clkPrev <= 1'b0;
    end else begin
      selSy   <= {selSy[SYNC-2:0], selN};
      clkSy   <= {clkSy[SYNC-2:0], sclk};
      dinSy   <= {dinSy[SYNC-2:0], sdi};
      clkPrev <= clkS;
    end
  end

  assign selS = selSy[SYNC-1];
  assign clkS = clkSy[SYNC-1];
  assign dinS = dinSy[SYNC-1];
  assign rise = clkS & ~clkPrev & ~selS;
  assign fall = ~clkS & clkPrev & ~selS;

  logic [CW-1:0]   bitCnt;
  logic [DW-2:0]   shiftIn;
  logic [DW-1:0]   nextBit;
  logic [AW-1:0]   cmdReg, addrReg;
  logic [DW-1:0]   outShift, wrData;
  logic            isRead, loadPend, wrPulse, doutR;

  assign nextBit = {shiftIn, dinS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftIn  <= '0;
      cmdReg   <= '0;
      addrReg  <= '0;
      outShift <= '0;
      wrData   <= '0;
      isRead   <= 1'b0;
      loadPend <= 1'b0;
      wrPulse  <= 1'b0;
      doutR    <= 1'b0;
    end else begin
      wrPulse  <= 1'b0;
      loadPend <= 1'b0;
      if (selS) begin
        bitCnt <= '0;
        isRead <= 1'b0;
        doutR  <= 1'b0;
      end else begin
        if (rise && bitCnt < CW'(FRAME)) begin
          shiftIn <= nextBit[DW-2:0];
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == CW'(AW - 1)) cmdReg <= nextBit[AW-1:0];
          if (bitCnt == CW'(2 * AW - 1)) begin
            addrReg <= nextBit[AW-1:0];
            if (cmdReg == CMD_RD) begin
              isRead   <= 1'b1;
              loadPend <= 1'b1;
            end
          end
          if (bitCnt == CW'(FRAME - 1) && cmdReg == CMD_WR) begin
            wrPulse <= 1'b1;
            wrData  <= nextBit;
          end
        end
        if (loadPend) outShift <= rdData;
        if (fall && isRead && bitCnt >= CW'(2 * AW)) begin
          doutR    <= outShift[DW-1];
          outShift <= {outShift[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign strobe = '{wrEn: wrPulse, addr: addrReg, data: wrData};
  assign sdo    = doutR;

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CW'(FRAME));
  a_r8_full_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> bitCnt == CW'(FRAME));
  a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!selS && !$past(selS) && doutR != $past(doutR)) |-> $past(fall));
endmodule

// File: rtl/ctlRegBank.sv
module ctlRegBank
  import ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [DW-1:0]   decodeTime,
  input  logic [DW-1:0]   sampleData,
  input  logic [DW-1:0]   header0,
  input  logic [DW-1:0]   header1,
  output logic [DW-1:0]   rdData,
  output logic [DW-1:0]   modeOut,
  output logic            powerDown,
  output logic [DW-1:0]   statusOut,
  output logic [DW-1:0]   clockOut,
  output logic [DW-1:0]   appAddrOut,
  output logic [DW/2-1:0] volLeft,
  output logic [DW/2-1:0] volRight,
  output logic [DW-1:0]   appCtrl0Out,
  output logic [DW-1:0]   appCtrl1Out,
  output logic [DW-1:0]   progDataOut,
  output logic [DW-1:0]   progAddrOut,
  output logic            progWrStb,
  output logic [NREG-1:0] wrStb
);
  logic [DW-1:0]   regs   [NSLOT];
  logic [DW-1:0]   rdSlot [NSLOT];
  logic [NREG-1:0] wrSel;
  logic [NREG-1:0] wrStbR;
  logic [DW-1:0]   progData, progAddr;
  logic            inRange;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wrSel[i] = strobe.wrEn && (strobe.addr == AW'(i)) && (RW_MASK[i] || WO_MASK[i]);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (RW_MASK[i]) begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[i] <= '0;
        else if (wrSel[i]) regs[i] <= strobe.data;
        else if (i == A_MODE) regs[i][MODE_SRST] <= 1'b0;
      end
      assign rdSlot[i] = regs[i];
    end else begin : g_other
      assign regs[i] = '0;
      if (i == A_TIME)      begin : g_t assign rdSlot[i] = decodeTime; end
      else if (i == A_SMP)  begin : g_s assign rdSlot[i] = sampleData; end
      else if (i == A_HDR0) begin : g_h0 assign rdSlot[i] = header0; end
      else if (i == A_HDR1) begin : g_h1 assign rdSlot[i] = header1; end
      else                  begin : g_z assign rdSlot[i] = '0; end
    end
  end

  assign inRange = strobe.addr < AW'(NREG);
  assign rdData  = inRange ? rdSlot[strobe.addr[IDXW-1:0]] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStbR   <= '0;
      progData <= '0;
      progAddr <= '0;
    end else begin
      wrStbR <= wrSel;
      if (wrSel[A_PDAT]) progData <= strobe.data;
      if (wrSel[A_PADR]) progAddr <= strobe.data;
      else if (wrStbR[A_PDAT]) progAddr <= progAddr + 1'b1;
    end
  end

  assign wrStb       = wrStbR;
  assign progWrStb   = wrStbR[A_PDAT];
  assign progDataOut = progData;
  assign progAddrOut = progAddr;
  assign modeOut     = regs[A_MODE];
  assign powerDown   = regs[A_MODE][MODE_PDN];
  assign statusOut   = regs[A_STAT];
  assign clockOut    = regs[A_CLK];
  assign appAddrOut  = regs[A_APPA];
  assign volLeft     = regs[A_VOL][DW-1:DW/2];
  assign volRight    = regs[A_VOL][DW/2-1:0];
  assign appCtrl0Out = regs[A_APC0];
  assign appCtrl1Out = regs[A_APC1];

  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    regs[A_MODE][MODE_SRST] |=> !regs[A_MODE][MODE_SRST]);
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    wrStbR[A_PDAT] |=> progAddr == $past(progAddr) + 1'b1);
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStbR));
endmodule

// File: rtl/ctlRegSlave.sv
module ctlRegSlave
  import ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdo,
  input  logic [15:0] decodeTime,
  input  logic [15:0] sampleData,
  input  logic [15:0] header0,
  input  logic [15:0] header1,
  output logic [15:0] modeOut,
  output logic        powerDown,
  output logic [15:0] statusOut,
  output logic [15:0] clockOut,
  output logic [15:0] appAddrOut,
  output logic [7:0]  volLeft,
  output logic [7:0]  volRight,
  output logic [15:0] appCtrl0Out,
  output logic [15:0] appCtrl1Out,
  output logic [15:0] progDataOut,
  output logic [15:0] progAddrOut,
  output logic        progWrStb,
  output logic [14:0] wrStb
);
  ctlStrobe_t    strobe;
  logic [DW-1:0] rdData;

  ctlSerialCtrl #(.SYNC(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdi(sdi),
    .rdData(rdData), .strobe(strobe), .sdo(sdo)
  );

  ctlRegBank u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .decodeTime(decodeTime), .sampleData(sampleData),
    .header0(header0), .header1(header1), .rdData(rdData),
    .modeOut(modeOut), .powerDown(powerDown), .statusOut(statusOut),
    .clockOut(clockOut), .appAddrOut(appAddrOut),
    .volLeft(volLeft), .volRight(volRight),
    .appCtrl0Out(appCtrl0Out), .appCtrl1Out(appCtrl1Out),
    .progDataOut(progDataOut), .progAddrOut(progAddrOut),
    .progWrStb(progWrStb), .wrStb(wrStb)
  );
endmodule

// File: tb/sim_ctlRegSlave.sv
`timescale 1ns/1ps
module sim_ctlRegSlave;
  localparam time HALF = 40ns;

  logic clk = 1'b0, rstN = 1'b0, selN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, powerDown, progWrStb;
  logic [15:0] decodeTime = 16'h1234, sampleData = 16'h8001;
  logic [15:0] header0 = 16'hFFE3, header1 = 16'h5A5A;
  logic [15:0] modeOut, statusOut, clockOut, appAddrOut, appCtrl0Out, appCtrl1Out;
  logic [15:0] progDataOut, progAddrOut;
  logic [7:0]  volLeft, volRight;
  logic [14:0] wrStb;

  int nChk = 0, nErr = 0;
  int progCnt = 0, modeHi = 0, stbCnt = 0;
  logic [15:0] capAddr = '0, capData = '0;
  logic [14:0] stbLast = '0;
  bit done = 0;

  always #2ns clk = ~clk;

  ctlRegSlave u0 (.*);

  always @(negedge clk) begin
    if (progWrStb) begin progCnt++; capAddr = progAddrOut; capData = progDataOut; end
    if (modeOut[2]) modeHi++;
    if (|wrStb) begin stbCnt++; stbLast = wrStb; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] a, input logic [15:0] d,
                      input int nbits, output logic [15:0] rd, output int hiSeen);
    logic [31:0] f;
    f = {c, a, d};
    rd = '0;
    hiSeen = 0;
    selN = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[31-i];
      #(HALF);
      if (i >= 16) rd = {rd[14:0], sdo};
      else if (sdo) hiSeen++;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
    #(HALF);
    selN = 1'b1;
    #(HALF * 2);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] r; int h;
    xfer(8'h02, a, d, 32, r, h);
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] r);
    int h;
    xfer(8'h03, a, 16'h0000, 32, r, h);
  endtask

  task automatic t_reset;
    chk("R10 sdo", sdo, 0);
    chk("R10 mode", modeOut, 0);
    chk("R10 clock", clockOut, 0);
    chk("R10 vol", {volLeft, volRight}, 0);
    chk("R10 progAddr", progAddrOut, 0);
    chk("R10 strobes", {progWrStb, wrStb}, 0);
  endtask

  task automatic t_readWrite;
    logic [15:0] r;
    int s0;
    s0 = stbCnt;
    wr(8'h03, 16'hA5C3);
    chk("R1 clock written", clockOut, 16'hA5C3);
    chk("R11 one strobe", stbCnt - s0, 1);
    chk("R11 strobe index", stbLast, 15'h0008);
    rdReg(8'h03, r);
    chk("R2 clock readback", r, 16'hA5C3);
    wr(8'h0E, 16'h0F0F);
    rdReg(8'h0E, r);
    chk("R1 appCtrl1", appCtrl1Out, 16'h0F0F);
    chk("R2 appCtrl1 read", r, 16'h0F0F);
    chk("R2 sdo idle", sdo, 0);
  endtask

  task automatic t_volume;
    logic [15:0] r;
    wr(8'h0B, 16'h12FE);
    chk("R6 left", volLeft, 8'h12);
    chk("R6 right", volRight, 8'hFE);
    chk("R11 vol strobe", stbLast, 15'h0800);
    rdReg(8'h0B, r);
    chk("R6 read", r, 16'h12FE);
  endtask

  task automatic t_readOnly;
    logic [15:0] r;
    int s0;
    rdReg(8'h04, r); chk("R4 time", r, 16'h1234);
    rdReg(8'h05, r); chk("R4 sample", r, 16'h8001);
    rdReg(8'h08, r); chk("R4 hdr0", r, 16'hFFE3);
    rdReg(8'h09, r); chk("R4 hdr1", r, 16'h5A5A);
    s0 = stbCnt;
    wr(8'h04, 16'h0000);
    rdReg(8'h04, r);
    chk("R4 write ignored", r, 16'h1234);
    chk("R4 no strobe", stbCnt - s0, 0);
  endtask

  task automatic t_writeOnlyReserved;
    logic [15:0] r;
    wr(8'h07, 16'h0033);
    rdReg(8'h07, r); chk("R5 base reads zero", r, 0);
    rdReg(8'h06, r); chk("R5 data reads zero", r, 0);
    wr(8'h0C, 16'hFFFF);
    rdReg(8'h0C, r); chk("R5 reserved 0C", r, 0);
    wr(8'h02, 16'hFFFF);
    rdReg(8'h02, r); chk("R5 reserved 02", r, 0);
    wr(8'h13, 16'h7777);
    chk("R5 out of range no alias", clockOut, 16'hA5C3);
    rdReg(8'h0F, r); chk("R5 0F reads zero", r, 0);
  endtask

  task automatic t_program;
    int p0;
    p0 = progCnt;
    wr(8'h07, 16'h0100);
    chk("R7 base set", progAddrOut, 16'h0100);
    wr(8'h06, 16'hBEEF);
    chk("R7 one pulse", progCnt - p0, 1);
    chk("R7 addr at pulse", capAddr, 16'h0100);
    chk("R7 data at pulse", capData, 16'hBEEF);
    chk("R7 base stepped", progAddrOut, 16'h0101);
    wr(8'h06, 16'hCAFE);
    chk("R7 second addr", capAddr, 16'h0101);
    chk("R7 second step", progAddrOut, 16'h0102);
  endtask

  task automatic t_abort;
    logic [15:0] r; int h, s0;
    s0 = stbCnt;
    xfer(8'h02, 8'h03, 16'h1111, 20, r, h);
    xfer(8'h02, 8'h03, 16'h2222, 31, r, h);
    chk("R8 abort keeps value", clockOut, 16'hA5C3);
    chk("R8 no strobe", stbCnt - s0, 0);
    wr(8'h03, 16'h3C3C);
    chk("R8 next frame clean", clockOut, 16'h3C3C);
  endtask

  task automatic t_badCommand;
    logic [15:0] r; int h, s0;
    s0 = stbCnt;
    xfer(8'h05, 8'h03, 16'h9999, 32, r, h);
    chk("R3 no write", clockOut, 16'h3C3C);
    chk("R3 no strobe", stbCnt - s0, 0);
    xfer(8'h01, 8'h03, 16'hFFFF, 32, r, h);
    chk("R3 sdo quiet", r, 0);
  endtask

  task automatic t_mode;
    logic [15:0] r;
    int m0;
    m0 = modeHi;
    wr(8'h00, 16'h0014);
    chk("R9 pulse length", modeHi - m0, 1);
    chk("R9 bit cleared", modeOut, 16'h0010);
    chk("R9 powerDown", powerDown, 1);
    rdReg(8'h00, r);
    chk("R9 read mode", r, 16'h0010);
  endtask

  initial begin
    #(200us);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    #20ns;
    @(negedge clk) rstN = 1'b1;
    #40ns;
    t_reset();
    t_readWrite();
    t_volume();
    t_readOnly();
    t_writeOnlyReserved();
    t_program();
    t_abort();
    t_badCommand();
    t_mode();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule